// File: doc/BRIEF.md
# Pulse-Density Tone and Ringer Generator

This block produces call-progress and ringing tones for a telephone handset or base station. A 3-bit frequency code picks one of eight audio tones and a 3-bit volume code picks one of eight loudness settings. The tone is built as a train of pulses at a fixed 32 kHz slot rate. Each pulse is positive, zero or negative, following a coarse sine shape. The loudness is set by how long each pulse stays on within its slot. The top volume code replaces the sine shape with a full-width square wave.

The ringer drive is a differential pair. A positive pulse raises `bzPos` and a negative pulse raises `bzNeg`. Both are low when the tone is off. A routing input sends the tone to the receive audio path instead of the ringer. In that case the pair stays low and a signed per-slot sample appears on `toneSample`.

All inputs are sampled once per slot, on the last master-clock cycle of the slot. A change therefore never cuts a pulse short or creates an extra one.

Top module: `tone_ringer`

## Requirements
- R1: The frequency code gives 400, 421, 444, 800, 1000, 1067, 1333 and 2000 Hz for codes 0 to 7. At every slot boundary the 16-bit phase advances by round(f·65536/32000), which is 819, 862, 909, 1638, 2048, 2185, 2730 and 4096 respectively.
- R2: A slot lasts 108 master-clock cycles. `toneEnable`, `freqSel`, `volSel` and `toRxPath` are sampled only on the last cycle of a slot, and they govern the whole following slot.
- R3: For volume codes 0 to 6, the polarity of a slot comes from phase bits [15:13]. Values 1 and 2 give +1, values 5 and 6 give −1, and all other values give 0.
- R4: A pulse occupies the first W cycles of its slot and is zero for the rest. W depends on the volume code: codes 0 to 7 give W = 3, 6, 13, 27, 54, 96, 24 and 108 (codes 0 to 5 correspond to −29, −23, −17, −11, −5 and 0 dB, and code 6 to −12 dB).
- R5: Volume code 7 gives a square wave. The slot polarity is +1 while phase bit 15 is 0 and −1 while it is 1, and the pulse fills all 108 cycles.
- R6: While the sampled enable is low, `bzPos`, `bzNeg` and `toneSample` are all zero. The phase restarts at 0, so the first enabled slot has phase 0.
- R7: While the sampled routing bit is 1, `bzPos` and `bzNeg` stay low. `toneSample` then holds polarity × W for the whole slot.
- R8: `bzPos` and `bzNeg` are never high together.
- R9: The outputs are registered. They show the slot state one master-clock cycle after that state appears.
- R10: While `rst` is high, all outputs are zero and the slot counter and phase are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 108 cycles per 32 kHz slot |
| rst | input | 1 | Synchronous reset, active high |
| toneEnable | input | 1 | Tone on when high |
| freqSel | input | 3 | Tone frequency code |
| volSel | input | 3 | Tone volume code |
| toRxPath | input | 1 | 1 sends the tone to the receive path instead of the ringer |
| bzPos | output | 1 | Ringer positive drive |
| bzNeg | output | 1 | Ringer negative drive |
| toneSample | output | 16 | Signed tone sample for the receive path |

## Verification
Two operations can land on the same clock edge: the slot-boundary sampling of new codes and the phase advance that uses the incoming frequency code. The edge that ends a slot also restarts the pulse of the next slot. The directed part of the bench deliberately changes codes on the cycle before a boundary, so that the new values are present exactly at the sampling edge. The random part changes inputs at arbitrary points inside slots. A cycle-accurate bench model, derived from the slot, phase and width rules, judges every output on every cycle. That model confirms that each change appears exactly one slot boundary later and never partway through a pulse.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef struct packed {
    logic advance;   // last cycle of a slot: sample codes, step phase
    logic inPulse;   // current cycle lies inside the active pulse width
  } toneStrobe_t;

  function automatic int toneHz(input logic [2:0] code);
    case (code)
      3'd0: return 400;
      3'd1: return 421;
      3'd2: return 444;
      3'd3: return 800;
      3'd4: return 1000;
      3'd5: return 1067;
      3'd6: return 1333;
      default: return 2000;
    endcase
  endfunction

  // Pulse width in master-clock cycles for a given volume code.
  function automatic int widthFor(input logic [2:0] code, input int slot);
    int perMille;
    int w;
    if (code == 3'd7) return slot;
    case (code)
      3'd0: perMille = 31;
      3'd1: perMille = 63;
      3'd2: perMille = 125;
      3'd3: perMille = 250;
      3'd4: perMille = 500;
      3'd5: perMille = 890;
      default: perMille = 223;
    endcase
    w = (slot * perMille) / 1000;
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/tone_ctrl.sv
module tone_ctrl import tone_pkg::*; #(
  parameter int SLOT_CYCLES = 108,
  parameter int CNT_W = $clog2(SLOT_CYCLES),
  parameter int WID_W = $clog2(SLOT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             toneEnable,
  input  logic [2:0]       volSel,
  input  logic             toRxPath,
  output toneStrobe_t      strobe,
  output logic             enQ,
  output logic             routeQ,
  output logic [2:0]       volQ,
  output logic [WID_W-1:0] pulseWidth
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLOT_CYCLES - 1);

  logic [CNT_W-1:0] slotCnt;
  logic             boundary;

  assign boundary = (slotCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
      enQ     <= 1'b0;
      routeQ  <= 1'b0;
      volQ    <= '0;
    end else begin
      slotCnt <= boundary ? '0 : slotCnt + 1'b1;
      if (boundary) begin
        enQ    <= toneEnable;
        routeQ <= toRxPath;
        volQ   <= volSel;
      end
    end
  end

  always_comb pulseWidth = WID_W'(widthFor(volQ, SLOT_CYCLES));

  always_comb begin
    strobe.advance = boundary;
    strobe.inPulse = (WID_W'(slotCnt) < pulseWidth);
  end

  // Codes only move at a slot boundary.
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(enQ) && $stable(routeQ) && $stable(volQ)));

  // After the last cycle of a slot, a new slot starts at count zero.
  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (slotCnt == '0));

endmodule

// File: rtl/tone_datapath.sv
module tone_datapath import tone_pkg::*; #(
  parameter int PHASE_W  = 16,
  parameter int PULSE_HZ = 32000,
  parameter int WID_W    = 7,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  toneStrobe_t                strobe,
  input  logic                       toneEnable,
  input  logic [2:0]                 freqSel,
  input  logic                       enQ,
  input  logic                       routeQ,
  input  logic [2:0]                 volQ,
  input  logic [WID_W-1:0]           pulseWidth,
  output logic                       bzPos,
  output logic                       bzNeg,
  output logic signed [SAMPLE_W-1:0] toneSample
);

  function automatic logic [PHASE_W-1:0] incFor(input logic [2:0] code);
    longint num;
    num = (longint'(toneHz(code)) << PHASE_W) + longint'(PULSE_HZ / 2);
    return PHASE_W'(num / longint'(PULSE_HZ));
  endfunction

  logic [PHASE_W-1:0]         phase;
  logic [2:0]                 sector;
  logic                       levelPos;
  logic                       levelNeg;
  logic signed [SAMPLE_W-1:0] widthS;

  assign sector = phase[PHASE_W-1 -: 3];
  assign widthS = SAMPLE_W'(pulseWidth);

  always_comb begin
    if (volQ == 3'd7) begin
      levelPos = !phase[PHASE_W-1];
      levelNeg = phase[PHASE_W-1];
    end else begin
      levelPos = (sector == 3'd1) || (sector == 3'd2);
      levelNeg = (sector == 3'd5) || (sector == 3'd6);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= '0;
      bzPos      <= 1'b0;
      bzNeg      <= 1'b0;
      toneSample <= '0;
    end else begin
      if (strobe.advance)
        phase <= (toneEnable && enQ) ? phase + incFor(freqSel) : '0;
      bzPos <= enQ && !routeQ && strobe.inPulse && levelPos;
      bzNeg <= enQ && !routeQ && strobe.inPulse && levelNeg;
      if (enQ && routeQ)
        toneSample <= levelPos ? widthS : (levelNeg ? -widthS : '0);
      else
        toneSample <= '0;
    end
  end

  assert_exclusive_drive_R8: assert property (@(posedge clk) disable iff (rst)
    !(bzPos && bzNeg));

  assert_route_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    routeQ |=> (!bzPos && !bzNeg));

  assert_off_silent_R6: assert property (@(posedge clk) disable iff (rst)
    !enQ |=> (!bzPos && !bzNeg && toneSample == '0));

  assert_phase_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && !enQ) |=> (phase == '0));

  assert_gap_low_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe.inPulse |=> (!bzPos && !bzNeg));

endmodule

// File: rtl/tone_ringer.sv
module tone_ringer import tone_pkg::*; #(
  parameter int SLOT_CYCLES = 108,
  parameter int PHASE_W     = 16,
  parameter int PULSE_HZ    = 32000,
  parameter int SAMPLE_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       toneEnable,
  input  logic [2:0]                 freqSel,
  input  logic [2:0]                 volSel,
  input  logic                       toRxPath,
  output logic                       bzPos,
  output logic                       bzNeg,
  output logic signed [SAMPLE_W-1:0] toneSample
);

  localparam int WID_W = $clog2(SLOT_CYCLES + 1);

  toneStrobe_t      strobe;
  logic             enQ;
  logic             routeQ;
  logic [2:0]       volQ;
  logic [WID_W-1:0] pulseWidth;

  tone_ctrl #(.SLOT_CYCLES(SLOT_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .toneEnable(toneEnable), .volSel(volSel),
    .toRxPath(toRxPath), .strobe(strobe), .enQ(enQ), .routeQ(routeQ),
    .volQ(volQ), .pulseWidth(pulseWidth)
  );

  tone_datapath #(
    .PHASE_W(PHASE_W), .PULSE_HZ(PULSE_HZ), .WID_W(WID_W), .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .toneEnable(toneEnable),
    .freqSel(freqSel), .enQ(enQ), .routeQ(routeQ), .volQ(volQ),
    .pulseWidth(pulseWidth), .bzPos(bzPos), .bzNeg(bzNeg),
    .toneSample(toneSample)
  );

endmodule

// File: tb/tone_ringer_tb.sv
module tone_ringer_tb;

  localparam int PERIOD = 10;
  localparam int SLOT = 108;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic toneEnable = 1'b0;
  logic [2:0] freqSel = '0;
  logic [2:0] volSel = '0;
  logic toRxPath = 1'b0;
  logic bzPos, bzNeg;
  logic signed [15:0] toneSample;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phaseTag = "R10";

  // reference model state
  int mSlot = 0;
  logic [15:0] mPhase = '0;
  logic mEnQ = 0, mRouteQ = 0;
  logic [2:0] mVolQ = '0;

  tone_ringer u_dut (
    .clk(clk), .rst(rst), .toneEnable(toneEnable), .freqSel(freqSel),
    .volSel(volSel), .toRxPath(toRxPath), .bzPos(bzPos), .bzNeg(bzNeg),
    .toneSample(toneSample)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int incOf(input logic [2:0] c);
    int t[8] = '{819, 862, 909, 1638, 2048, 2185, 2730, 4096};
    return t[c];
  endfunction

  function automatic int widthOf(input logic [2:0] c);
    int t[8] = '{3, 6, 13, 27, 54, 96, 24, 108};
    return t[c];
  endfunction

  function automatic int levelOf(input logic [15:0] ph, input logic [2:0] v);
    int s;
    if (v == 3'd7) return ph[15] ? -1 : 1;
    s = int'(ph[15:13]);
    if (s == 1 || s == 2) return 1;
    if (s == 5 || s == 6) return -1;
    return 0;
  endfunction

  task automatic tick();
    logic eP, eN;
    logic signed [15:0] eS;
    int lvl, w;
    string why;
    @(negedge clk);
    if (rst) begin
      checks++;
      if (bzPos !== 1'b0 || bzNeg !== 1'b0 || toneSample !== 16'sd0) begin
        errors++;
        $display("FAIL R10 reset: pos/neg/sample=%b/%b/%0d expected 0/0/0",
                 bzPos, bzNeg, toneSample);
      end
      return;
    end
    lvl = levelOf(mPhase, mVolQ);
    w = widthOf(mVolQ);
    eP = mEnQ && !mRouteQ && (mSlot < w) && (lvl == 1);
    eN = mEnQ && !mRouteQ && (mSlot < w) && (lvl == -1);
    eS = (mEnQ && mRouteQ) ? 16'(lvl * w) : 16'sd0;
    if (!mEnQ) why = "R6";
    else if (mRouteQ) why = "R7";
    else if (mVolQ == 3'd7) why = "R5";
    else if (mSlot >= w) why = "R4";
    else why = "R3";
    checks++;
    if (bzPos !== eP || bzNeg !== eN || toneSample !== eS) begin
      errors++;
      $display("FAIL %s %s: pos/neg/sample=%b/%b/%0d expected %b/%b/%0d",
               phaseTag, why, bzPos, bzNeg, toneSample, eP, eN, eS);
    end
    checks++;
    if (bzPos === 1'b1 && bzNeg === 1'b1) begin
      errors++;
      $display("FAIL R8 both drives high: pos/neg=1/1 expected not both");
    end
    // model step for the edge that follows this sample point
    if (mSlot == SLOT - 1) begin
      mPhase = (toneEnable && mEnQ) ? mPhase + 16'(incOf(freqSel)) : 16'd0;
      mEnQ = toneEnable;
      mRouteQ = toRxPath;
      mVolQ = volSel;
      mSlot = 0;
    end else begin
      mSlot++;
    end
  endtask

  task automatic toPreBoundary();
    while (mSlot != SLOT - 2) tick();
  endtask

  task automatic runSlots(input int n);
    for (int i = 0; i < n * SLOT; i++) tick();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4242);
    for (int i = 0; i < 5; i++) tick();   // R10 reset checks
    rst = 1'b0;
    runSlots(1);

    // R1: every frequency code, sine levels, square, routed, then off.
    // Codes change on the cycle before a boundary (R2 coincidence).
    phaseTag = "R1";
    for (int f = 0; f < 8; f++) begin
      toPreBoundary();
      freqSel = 3'(f); volSel = 3'd5; toneEnable = 1'b1; toRxPath = 1'b0;
      runSlots(6);
      toPreBoundary();
      volSel = 3'(f);
      runSlots(2);
      toPreBoundary();
      volSel = 3'd7;
      runSlots(3);
      toPreBoundary();
      toRxPath = 1'b1; volSel = 3'(7 - f);
      runSlots(2);
      toPreBoundary();
      toneEnable = 1'b0; toRxPath = 1'b0;
      runSlots(1);
    end

    // R2 R9: random changes at arbitrary cycles inside slots
    phaseTag = "R2 R9";
    toneEnable = 1'b1;
    for (int i = 0; i < 300 * SLOT; i++) begin
      tick();
      if ($urandom_range(0, 149) == 0) begin
        case ($urandom_range(0, 3))
          0: freqSel = 3'($urandom_range(0, 7));
          1: volSel = 3'($urandom_range(0, 7));
          2: toRxPath = ($urandom_range(0, 3) == 0);
          default: toneEnable = ($urandom_range(0, 7) != 0);
        endcase
      end
    end
    finish();
  end

endmodule